// File: doc/BRIEF.md
# Load/Store Address and Extend Unit

This unit sits between the decode stage and the data memory port of a processor core. It serves single-register load and store transfers. For each operation it takes the base register value and the offset operands, together with mode flags. From these it forms the effective memory address and the byte lane mask. It also decides whether the base register must be updated, and with which value. It then issues one request on a simple synchronous memory port and waits for the memory's acknowledge.

On completion the unit returns three things in one cycle: a one-cycle base-update strobe, the updated base value, and the loaded data. Byte and halfword loads are taken from the correct lane of the 32-bit read word and zero-extended. The offset has two possible sources:

- a 12-bit immediate, or
- a register value shifted left by a 5-bit amount.

The offset is then added to or subtracted from the base. There are three addressing modes:

- plain offset, where the base is unchanged;
- pre-indexed with update, where the access and the new base both use base±offset;
- post-indexed, where the access uses the raw base and the new base is base±offset.

Top module: `lsu_addr_unit`

## Requirements
- R1: In offset mode (op_mode=0, and also the unused code 3), mem_addr is base±offset and wb_en stays 0 when the access completes.
- R2: In pre-indexed update mode (op_mode=1), mem_addr is base±offset, and on completion wb_en is 1 with wb_value equal to that same address.
- R3: In post-indexed mode (op_mode=2), mem_addr is the unmodified base, and on completion wb_en is 1 with wb_value equal to base±offset.
- R4: With op_use_imm=1 the offset is op_imm zero-extended from 12 bits. With op_use_imm=0 it is op_offreg shifted left by op_shamt bits (shift 2 multiplies by four).
- R5: op_up=1 adds the offset to the base and op_up=0 subtracts it, modulo 2^32.
- R6: A byte load (op_size=0) returns the byte in lane mem_addr[1:0] of mem_rdata (lane n = bits 8n+7:8n) in ld_data[7:0], with bits 31:8 cleared.
- R7: A halfword load (op_size=1) returns bits 31:16 of mem_rdata if mem_addr[1]=1, else bits 15:0, in ld_data[15:0], with bits 31:16 cleared. A word load (op_size=2) returns all 32 bits.
- R8: mem_be is 4'b1111 for words. For halfwords it is 4'b1100 or 4'b0011 as mem_addr[1] is 1 or 0. For bytes it is the single bit numbered mem_addr[1:0].
- R9: A store (op_store=1) drives mem_we=1 and puts the data on mem_wdata: all 32 bits for a word, the low halfword copied twice for a halfword, the low byte copied four times for a byte. Base-update rules for stores are those of R1 to R3.
- R10: mem_req rises in the cycle after an operation is accepted. It then holds, with mem_addr, mem_be, mem_we and mem_wdata stable, until the cycle in which mem_ack is 1. op_ready is 0 while mem_req is 1, and op_valid is ignored during that time.
- R11: done and wb_en are each high for exactly one cycle, the cycle after mem_ack is seen. wb_en never rises without done.
- R12: After reset op_ready is 1 and mem_req, done and wb_en are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation taken when op_valid |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | 0 byte, 1 halfword, 2 word |
| op_mode | input | 2 | 0 offset, 1 pre-indexed update, 2 post-indexed |
| op_use_imm | input | 1 | Offset from immediate instead of register |
| op_up | input | 1 | 1 add offset, 0 subtract |
| op_base | input | 32 | Base register value |
| op_offreg | input | 32 | Offset register value |
| op_imm | input | 12 | Immediate offset |
| op_shamt | input | 5 | Left shift applied to the register offset |
| op_wdata | input | 32 | Store source data |
| mem_req | output | 1 | Memory request pending |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_be | output | 4 | Byte lane enables |
| mem_wdata | output | 32 | Write data, lane-replicated |
| mem_ack | input | 1 | Memory completes the pending request |
| mem_rdata | input | 32 | Read word, valid with mem_ack |
| done | output | 1 | One-cycle completion pulse |
| wb_en | output | 1 | One-cycle base-register update strobe |
| wb_value | output | 32 | New base value |
| ld_data | output | 32 | Extended load result |

## Verification
In the completion cycle, the base update and the load result land together. A pre-indexed or post-indexed load therefore presents wb_en, wb_value and the extended ld_data on the same cycle. The bench drives such loads and judges all three values at that one sample point. It then checks, one cycle later, that wb_en and done have both dropped. A second collision is a new op_valid arriving while a request is still waiting for mem_ack. The bench offers a different operation during a stalled request and checks three things: op_ready is low, mem_addr and mem_be keep the first operation's values, and the completion reports only the first operation's results.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int XLEN   = 32;
  localparam int IMM_W  = 12;
  localparam int SH_W   = 5;
  localparam int LANES  = XLEN / 8;
  localparam int LSB_W  = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } xfer_size_e;

  typedef enum logic [1:0] {
    AM_OFFSET = 2'd0,
    AM_PRE_UP = 2'd1,
    AM_POST   = 2'd2,
    AM_RSVD   = 2'd3
  } addr_mode_e;

  // offset operand: immediate zero-extended, or register shifted left
  function automatic logic [XLEN-1:0] pick_offset(
      input logic            use_imm,
      input logic [IMM_W-1:0] imm,
      input logic [XLEN-1:0] reg_val,
      input logic [SH_W-1:0] shamt);
    if (use_imm) return {{(XLEN-IMM_W){1'b0}}, imm};
    return reg_val << shamt;
  endfunction

  function automatic logic [XLEN-1:0] add_sub(
      input logic [XLEN-1:0] base,
      input logic [XLEN-1:0] off,
      input logic            up);
    return up ? (base + off) : (base - off);
  endfunction

  function automatic logic [LANES-1:0] lane_mask(
      input xfer_size_e      sz,
      input logic [LSB_W-1:0] lsb);
    logic [LANES-1:0] m;
    case (sz)
      SZ_BYTE: m = LANES'(1) << lsb;
      SZ_HALF: m = lsb[1] ? LANES'(4'b1100) : LANES'(4'b0011);
      default: m = '1;
    endcase
    return m;
  endfunction

  function automatic logic [XLEN-1:0] zext_lane(
      input xfer_size_e      sz,
      input logic [LSB_W-1:0] lsb,
      input logic [XLEN-1:0] word);
    logic [XLEN-1:0] r;
    case (sz)
      SZ_BYTE: r = {{(XLEN-8){1'b0}},  word[{lsb, 3'b000} +: 8]};
      SZ_HALF: r = {{(XLEN-16){1'b0}}, word[{lsb[1], 4'b0000} +: 16]};
      default: r = word;
    endcase
    return r;
  endfunction

  function automatic logic [XLEN-1:0] replicate_store(
      input xfer_size_e      sz,
      input logic [XLEN-1:0] src);
    logic [XLEN-1:0] r;
    case (sz)
      SZ_BYTE: r = {LANES{src[7:0]}};
      SZ_HALF: r = {(LANES/2){src[15:0]}};
      default: r = src;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/lsu_addr_calc.sv
module lsu_addr_calc
  import lsu_pkg::*;
(
  input  logic [XLEN-1:0]  base,
  input  logic [XLEN-1:0]  offreg,
  input  logic [IMM_W-1:0] imm,
  input  logic [SH_W-1:0]  shamt,
  input  logic             use_imm,
  input  logic             up,
  input  addr_mode_e       mode,
  output logic [XLEN-1:0]  acc_addr,
  output logic [XLEN-1:0]  new_base,
  output logic             upd_base
);
  logic [XLEN-1:0] off_val;
  logic [XLEN-1:0] indexed;

  assign off_val  = pick_offset(use_imm, imm, offreg, shamt);
  assign indexed  = add_sub(base, off_val, up);
  assign new_base = indexed;

  always_comb begin
    case (mode)
      AM_PRE_UP: begin acc_addr = indexed; upd_base = 1'b1; end
      AM_POST:   begin acc_addr = base;    upd_base = 1'b1; end
      default:   begin acc_addr = indexed; upd_base = 1'b0; end
    endcase
  end
endmodule

// File: rtl/lsu_load_fmt.sv
module lsu_load_fmt
  import lsu_pkg::*;
(
  input  xfer_size_e       size,
  input  logic [LSB_W-1:0] lsb,
  input  logic [XLEN-1:0]  rword,
  output logic [XLEN-1:0]  result
);
  assign result = zext_lane(size, lsb, rword);
endmodule

// File: rtl/lsu_req_ctrl.sv
module lsu_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic offer,
  input  logic ack,
  output logic idle,
  output logic pending,
  output logic accept,
  output logic complete
);
  logic busy_q;

  assign idle     = ~busy_q;
  assign pending  = busy_q;
  assign accept   = offer & ~busy_q;
  assign complete = busy_q & ack;

  always_ff @(posedge clk) begin
    if (!rst_n)        busy_q <= 1'b0;
    else if (accept)   busy_q <= 1'b1;
    else if (complete) busy_q <= 1'b0;
  end

  // R10
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending);
  // R10
  no_accept_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> !accept);
endmodule

// File: rtl/lsu_addr_unit.sv
module lsu_addr_unit
  import lsu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic              op_store,
  input  logic [1:0]        op_size,
  input  logic [1:0]        op_mode,
  input  logic              op_use_imm,
  input  logic              op_up,
  input  logic [XLEN-1:0]   op_base,
  input  logic [XLEN-1:0]   op_offreg,
  input  logic [IMM_W-1:0]  op_imm,
  input  logic [SH_W-1:0]   op_shamt,
  input  logic [XLEN-1:0]   op_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [XLEN-1:0]   mem_addr,
  output logic [LANES-1:0]  mem_be,
  output logic [XLEN-1:0]   mem_wdata,
  input  logic              mem_ack,
  input  logic [XLEN-1:0]   mem_rdata,
  output logic              done,
  output logic              wb_en,
  output logic [XLEN-1:0]   wb_value,
  output logic [XLEN-1:0]   ld_data
);
  // named internal events
  logic accept, complete, idle, pending;
  logic [XLEN-1:0] calc_addr, calc_base;
  logic            calc_upd;
  logic [XLEN-1:0] fmt_data;

  // captured operation
  logic [XLEN-1:0]  addr_q, newbase_q, wdata_q;
  logic [LANES-1:0] be_q;
  logic             upd_q, store_q;
  xfer_size_e       size_q;

  // completion outputs
  logic             done_q, wben_q;
  logic [XLEN-1:0]  wbv_q, ld_q;

  lsu_addr_calc u_calc (
    .base     (op_base),
    .offreg   (op_offreg),
    .imm      (op_imm),
    .shamt    (op_shamt),
    .use_imm  (op_use_imm),
    .up       (op_up),
    .mode     (addr_mode_e'(op_mode)),
    .acc_addr (calc_addr),
    .new_base (calc_base),
    .upd_base (calc_upd)
  );

  lsu_req_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .offer    (op_valid),
    .ack      (mem_ack),
    .idle     (idle),
    .pending  (pending),
    .accept   (accept),
    .complete (complete)
  );

  lsu_load_fmt u_fmt (
    .size   (size_q),
    .lsb    (addr_q[LSB_W-1:0]),
    .rword  (mem_rdata),
    .result (fmt_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      newbase_q <= '0;
      wdata_q   <= '0;
      be_q      <= '0;
      upd_q     <= 1'b0;
      store_q   <= 1'b0;
      size_q    <= SZ_WORD;
    end else if (accept) begin
      addr_q    <= calc_addr;
      newbase_q <= calc_base;
      wdata_q   <= replicate_store(xfer_size_e'(op_size), op_wdata);
      be_q      <= lane_mask(xfer_size_e'(op_size), calc_addr[LSB_W-1:0]);
      upd_q     <= calc_upd;
      store_q   <= op_store;
      size_q    <= xfer_size_e'(op_size);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wben_q <= 1'b0;
      wbv_q  <= '0;
      ld_q   <= '0;
    end else begin
      done_q <= complete;
      wben_q <= complete & upd_q;
      if (complete) begin
        wbv_q <= newbase_q;
        if (!store_q) ld_q <= fmt_data;
      end
    end
  end

  assign op_ready  = idle;
  assign mem_req   = pending;
  assign mem_we    = store_q;
  assign mem_addr  = addr_q;
  assign mem_be    = be_q;
  assign mem_wdata = wdata_q;
  assign done      = done_q;
  assign wb_en     = wben_q;
  assign wb_value  = wbv_q;
  assign ld_data   = ld_q;

  // R10
  req_payload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_be) && $stable(mem_wdata)));
  // R10
  ready_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !op_ready);
  // R11
  wb_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |=> !wb_en);
  // R11
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);
  // R11
  done_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> done);
  // R8
  byte_lane_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && size_q == SZ_BYTE) |-> $countones(mem_be) == 1);
endmodule

// File: tb/lsu_addr_unit_tb.sv
module lsu_addr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_store = 1'b0, op_use_imm = 1'b0, op_up = 1'b0;
  logic [1:0]  op_size = 2'd0, op_mode = 2'd0;
  logic [31:0] op_base = '0, op_offreg = '0, op_wdata = '0, mem_rdata = '0;
  logic [11:0] op_imm = '0;
  logic [4:0]  op_shamt = '0;
  logic        mem_ack = 1'b0;
  logic        op_ready, mem_req, mem_we, done, wb_en;
  logic [31:0] mem_addr, mem_wdata, wb_value, ld_data;
  logic [3:0]  mem_be;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lsu_addr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .op_store(op_store), .op_size(op_size), .op_mode(op_mode),
    .op_use_imm(op_use_imm), .op_up(op_up), .op_base(op_base),
    .op_offreg(op_offreg), .op_imm(op_imm), .op_shamt(op_shamt),
    .op_wdata(op_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .wb_en(wb_en),
    .wb_value(wb_value), .ld_data(ld_data)
  );

  typedef struct packed {
    logic        st;
    logic [1:0]  sz;
    logic [1:0]  md;
    logic        isel;
    logic        up;
    logic [31:0] base;
    logic [31:0] offreg;
    logic [11:0] imm;
    logic [4:0]  sh;
    logic [31:0] wd;
    logic [31:0] rd;
    logic [31:0] e_addr;
    logic [3:0]  e_be;
    logic        e_wben;
    logic [31:0] e_wb;
    logic [31:0] e_data;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    // R1 R4 R5 R8: word load, offset mode, immediate, add
    '{1'b0, 2'd2, 2'd0, 1'b1, 1'b1, 32'h0000_1000, 32'h0, 12'h010, 5'd0, 32'h0, 32'hDEAD_BEEF,
      32'h0000_1010, 4'b1111, 1'b0, 32'h0, 32'hDEAD_BEEF},
    // R2 R4: word load, pre-indexed, register << 2
    '{1'b0, 2'd2, 2'd1, 1'b0, 1'b1, 32'h0000_2000, 32'h3, 12'h0, 5'd2, 32'h0, 32'h1234_5678,
      32'h0000_200C, 4'b1111, 1'b1, 32'h0000_200C, 32'h1234_5678},
    // R3 R5 R6: byte load lane 3, post-indexed, subtract
    '{1'b0, 2'd0, 2'd2, 1'b0, 1'b0, 32'h0000_3003, 32'h10, 12'h0, 5'd0, 32'h0, 32'hA1B2_C3D4,
      32'h0000_3003, 4'b1000, 1'b1, 32'h0000_2FF3, 32'h0000_00A1},
    // R6 R8: byte load lane 1
    '{1'b0, 2'd0, 2'd0, 1'b1, 1'b1, 32'h0000_4000, 32'h0, 12'h001, 5'd0, 32'h0, 32'hA1B2_C3D4,
      32'h0000_4001, 4'b0010, 1'b0, 32'h0, 32'h0000_00C3},
    // R7 R2 R5: upper halfword, pre-indexed, immediate subtract
    '{1'b0, 2'd1, 2'd1, 1'b1, 1'b0, 32'h0000_5008, 32'h0, 12'h006, 5'd0, 32'h0, 32'h8765_4321,
      32'h0000_5002, 4'b1100, 1'b1, 32'h0000_5002, 32'h0000_8765},
    // R7 R3 R4: lower halfword, post-indexed, register << 1
    '{1'b0, 2'd1, 2'd2, 1'b0, 1'b1, 32'h0000_6000, 32'h20, 12'h0, 5'd1, 32'h0, 32'hFFFF_8001,
      32'h0000_6000, 4'b0011, 1'b1, 32'h0000_6040, 32'h0000_8001},
    // R9 R3: word store, post-indexed
    '{1'b1, 2'd2, 2'd2, 1'b1, 1'b1, 32'h0000_7000, 32'h0, 12'h008, 5'd0, 32'hCAFE_F00D, 32'h0,
      32'h0000_7000, 4'b1111, 1'b1, 32'h0000_7008, 32'hCAFE_F00D},
    // R9 R1 R8: byte store, register << 4
    '{1'b1, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0000_8000, 32'h1, 12'h0, 5'd4, 32'h1234_56AB, 32'h0,
      32'h0000_8010, 4'b0001, 1'b0, 32'h0, 32'hABAB_ABAB},
    // R9 R2: halfword store, pre-indexed subtract
    '{1'b1, 2'd1, 2'd1, 1'b0, 1'b0, 32'h0000_9000, 32'h2, 12'h0, 5'd0, 32'h0000_BEEF, 32'h0,
      32'h0000_8FFE, 4'b1100, 1'b1, 32'h0000_8FFE, 32'hBEEF_BEEF},
    // R5 R1: subtract wraps below zero
    '{1'b0, 2'd2, 2'd0, 1'b1, 1'b0, 32'h0000_0004, 32'h0, 12'h008, 5'd0, 32'h0, 32'h0000_0000,
      32'hFFFF_FFFC, 4'b1111, 1'b0, 32'h0, 32'h0000_0000},
    // R1: reserved mode code 3 acts as offset mode, max immediate
    '{1'b0, 2'd2, 2'd3, 1'b1, 1'b1, 32'h0001_0000, 32'h0, 12'hFFF, 5'd0, 32'h0, 32'h5555_AAAA,
      32'h0001_0FFF, 4'b1111, 1'b0, 32'h0, 32'h5555_AAAA}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive_op(input vec_t v);
    op_store = v.st; op_size = v.sz; op_mode = v.md; op_use_imm = v.isel;
    op_up = v.up; op_base = v.base; op_offreg = v.offreg; op_imm = v.imm;
    op_shamt = v.sh; op_wdata = v.wd;
  endtask

  task automatic run_vec(input vec_t v, input int stall);
    @(negedge clk);
    drive_op(v);
    op_valid = 1'b1;
    @(negedge clk);
    op_valid = 1'b0;
    check("R10", "mem_req", {31'b0, mem_req}, 32'd1);
    check("R1-3 addr", "mem_addr", mem_addr, v.e_addr);
    check("R8", "mem_be", {28'b0, mem_be}, {28'b0, v.e_be});
    check("R9", "mem_we", {31'b0, mem_we}, {31'b0, v.st});
    if (v.st) check("R9", "mem_wdata", mem_wdata, v.e_data);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      check("R10", "stall mem_req", {31'b0, mem_req}, 32'd1);
      check("R10", "stall addr", mem_addr, v.e_addr);
    end
    mem_ack = 1'b1;
    mem_rdata = v.rd;
    @(negedge clk);
    mem_ack = 1'b0;
    mem_rdata = 32'h0;
    check("R11", "done", {31'b0, done}, 32'd1);
    check("R11", "wb_en", {31'b0, wb_en}, {31'b0, v.e_wben});
    if (v.e_wben) check("R2 R3", "wb_value", wb_value, v.e_wb);
    if (!v.st) check("R6 R7", "ld_data", ld_data, v.e_data);
    check("R10", "mem_req low", {31'b0, mem_req}, 32'd0);
    @(negedge clk);
    check("R11", "done pulse end", {31'b0, done}, 32'd0);
    check("R11", "wb_en pulse end", {31'b0, wb_en}, 32'd0);
  endtask

  initial begin
    int cnt = 0;
    while (!finished && cnt < 20000) begin
      @(posedge clk);
      cnt++;
    end
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    vec_t alt;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12", "op_ready", {31'b0, op_ready}, 32'd1);
    check("R12", "mem_req", {31'b0, mem_req}, 32'd0);
    check("R12", "done", {31'b0, done}, 32'd0);
    check("R12", "wb_en", {31'b0, wb_en}, 32'd0);
    rst_n = 1'b1;

    for (int k = 0; k < NV; k++) run_vec(VEC[k], k % 3);

    // R10: a second op offered while the first waits is ignored
    alt = VEC[1];
    alt.base = 32'h0000_ABC0;
    @(negedge clk);
    drive_op(VEC[2]);
    op_valid = 1'b1;
    @(negedge clk);
    drive_op(alt);
    for (int i = 0; i < 3; i++) begin
      check("R10", "busy op_ready", {31'b0, op_ready}, 32'd0);
      check("R10", "busy addr held", mem_addr, VEC[2].e_addr);
      check("R10", "busy be held", {28'b0, mem_be}, {28'b0, VEC[2].e_be});
      @(negedge clk);
    end
    op_valid = 1'b0;
    mem_ack = 1'b1;
    mem_rdata = VEC[2].rd;
    @(negedge clk);
    mem_ack = 1'b0;
    check("R10", "first op result", ld_data, VEC[2].e_data);
    check("R10", "first op wb", wb_value, VEC[2].e_wb);
    check("R10", "idle after", {31'b0, mem_req}, 32'd0);
    @(negedge clk);
    check("R10", "no stray request", {31'b0, mem_req}, 32'd0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule